// File: doc/BRIEF.md
# Field-Proportional PWM Duty Generator

This block turns a signed digital magnetic-field sample into a single pulse-width-modulated output. Three trim codes shape the result. The first sets the carrier frequency. The second sets the quiescent duty, which is the duty produced when no field is present. The third sets the gain that converts field into duty. The duty is the quiescent value plus the scaled field. It is then held inside a lower and an upper limit. Because of these limits, a receiver that sees a duty outside the band knows there is a wiring or supply fault.

Each carrier period is divided into `SLOTS` equal slots. Each slot lasts `DIV_BASE + freq_trim*DIV_STEP` system clocks. A higher frequency code therefore gives a longer period and a lower carrier frequency. The output is high for the first `duty` slots of a period and low for the rest. The duty and the period length are both captured only at the boundary between periods.

Calibration is optional. With `cal_en_i` high, the first `CAL_PERIODS` periods after reset run at the quiescent duty whatever the field is. The output then starts to follow the field on the next period.

Top module: `sensor_pwm_gen`

## Requirements
- R1: While `rst` is high, `pwm_o` is low. It stays low from the first clock edge at which reset is sampled.
- R2: With a zero field, the duty equals the quiescent duty, counted in slots as follows:
  - With `qdc_trim_i[8]`=0, the duty is `SLOTS/2 + qdc_trim_i[7:0]`.
  - With `qdc_trim_i[8]`=1, the duty is `SLOTS/2 - (qdc_trim_i - 255)`.
- R3: A nonzero field adds `floor(field_i * (SENS_BASE + sens_trim_i) / 2^SENS_SHIFT)` slots to the quiescent duty. A positive field raises the duty and a negative field lowers it.
- R4: The duty in slots saturates to the range [`SLOTS*CLAMP_LO_PCT/100`, `SLOTS*CLAMP_HI_PCT/100`]. The output is high for exactly `duty*(DIV_BASE+freq_trim_i*DIV_STEP)` clocks at the start of each period.
- R5: Each period lasts `SLOTS*(DIV_BASE + freq_trim_i*DIV_STEP)` clocks. Code 0 is the shortest period and code 15 the longest.
- R6: When `cal_en_i` is high at the start of each period, periods 0 to `CAL_PERIODS-1` after reset run at the clamped quiescent duty of R2, whatever `field_i` is.
- R7: Period `CAL_PERIODS` after reset, and every later one, follows the field as in R3. With `cal_en_i` low, period 0 already follows the field.
- R8: All inputs are sampled only at a period boundary. A change made during a period leaves that period unchanged and takes effect in the next one.
- R9: The first period begins on the first clock edge after reset is released, with the output high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| field_i | input | FIELD_W | Signed field sample; positive means south |
| sens_trim_i | input | 8 | Sensitivity trim; 0 gives the lowest gain, 255 the highest |
| qdc_trim_i | input | 9 | Quiescent duty trim; bit 8 selects a downward offset |
| freq_trim_i | input | 4 | Carrier trim; each step lengthens each slot by DIV_STEP clocks |
| cal_en_i | input | 1 | Enables the quiescent-duty window after reset |
| pwm_o | output | 1 | PWM output, active high |

## Verification
The calibration window is the hardest situation to reach, because it exists only in the first periods after a reset. The bench asserts reset while applying a large field with calibration enabled. It then measures each period back to back from the first rising edge, checking that the quiescent duty holds for exactly the window length and that the field appears in the next period. The boundary latching of R8 is forced by changing the field on the first high sample of a period and measuring that period and the one after it.

// File: rtl/sensor_pwm_gen.sv
module sensor_pwm_gen #(
  parameter int FIELD_W      = 12,
  parameter int SLOTS        = 1000,
  parameter int DIV_BASE     = 71,
  parameter int DIV_STEP     = 3,
  parameter int CAL_PERIODS  = 100,
  parameter int SENS_BASE    = 64,
  parameter int SENS_SHIFT   = 8,
  parameter int CLAMP_LO_PCT = 7,
  parameter int CLAMP_HI_PCT = 93
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic signed [FIELD_W-1:0] field_i,
  input  logic [7:0]                sens_trim_i,
  input  logic [8:0]                qdc_trim_i,
  input  logic [3:0]                freq_trim_i,
  input  logic                      cal_en_i,
  output logic                      pwm_o
);

  localparam int SLOT_W  = $clog2(SLOTS + 1);
  localparam int DIV_TOP = DIV_BASE + 15 * DIV_STEP;
  localparam int DIV_W   = $clog2(DIV_TOP + 1);
  localparam int CAL_W   = $clog2(CAL_PERIODS + 1);
  localparam int GAIN_W  = $clog2(SENS_BASE + 256) + 1;
  localparam int PROD_W  = FIELD_W + GAIN_W;
  localparam int SUM_W   = PROD_W + SLOT_W + 10;
  localparam int LO_SLOT = SLOTS * CLAMP_LO_PCT / 100;
  localparam int HI_SLOT = SLOTS * CLAMP_HI_PCT / 100;

  logic              started;
  logic [SLOT_W-1:0] slot_cnt, duty_lat, duty_next;
  logic [DIV_W-1:0]  div_cnt, div_lat, div_next;
  logic [CAL_W-1:0]  cal_cnt;
  logic              slot_end, wrap, in_cal;

  logic signed [GAIN_W-1:0] gain;
  logic signed [PROD_W-1:0] prod;
  logic signed [SUM_W-1:0]  prod_x, scaled, qoff, quies, raw;

  assign gain   = $signed(GAIN_W'(SENS_BASE) + GAIN_W'(sens_trim_i));
  assign prod   = PROD_W'(field_i) * PROD_W'(gain);
  assign prod_x = SUM_W'(prod);
  assign scaled = prod_x >>> SENS_SHIFT;

  assign qoff  = qdc_trim_i[8] ? SUM_W'(0) - SUM_W'(qdc_trim_i[7:0]) - SUM_W'(1)
                               : SUM_W'(qdc_trim_i[7:0]);
  assign quies = SUM_W'(SLOTS / 2) + qoff;

  assign in_cal = cal_en_i && (cal_cnt < CAL_W'(CAL_PERIODS));
  assign raw    = in_cal ? quies : quies + scaled;

  always_comb begin
    if (raw < SUM_W'(LO_SLOT))      duty_next = SLOT_W'(LO_SLOT);
    else if (raw > SUM_W'(HI_SLOT)) duty_next = SLOT_W'(HI_SLOT);
    else                            duty_next = raw[SLOT_W-1:0];
  end

  assign div_next = DIV_W'(DIV_BASE) + DIV_W'(freq_trim_i) * DIV_W'(DIV_STEP);

  assign slot_end = (div_cnt == div_lat - DIV_W'(1));
  assign wrap     = !started || (slot_end && slot_cnt == SLOT_W'(SLOTS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      started  <= 1'b0;
      slot_cnt <= '0;
      div_cnt  <= '0;
      duty_lat <= '0;
      div_lat  <= DIV_W'(DIV_BASE);
      cal_cnt  <= '0;
    end else if (wrap) begin
      started  <= 1'b1;
      slot_cnt <= '0;
      div_cnt  <= '0;
      duty_lat <= duty_next;
      div_lat  <= div_next;
      if (cal_cnt < CAL_W'(CAL_PERIODS)) cal_cnt <= cal_cnt + CAL_W'(1);
    end else if (slot_end) begin
      div_cnt  <= '0;
      slot_cnt <= slot_cnt + SLOT_W'(1);
    end else begin
      div_cnt  <= div_cnt + DIV_W'(1);
    end
  end

  assign pwm_o = started && (slot_cnt < duty_lat);

endmodule

// File: rtl/sensor_pwm_gen_chk.sv
module sensor_pwm_gen_chk #(
  parameter int SLOTS       = 1000,
  parameter int SLOT_W      = 10,
  parameter int DIV_W       = 7,
  parameter int CAL_W       = 7,
  parameter int CAL_PERIODS = 100,
  parameter int LO_SLOT     = 70,
  parameter int HI_SLOT     = 930
) (
  input logic              clk,
  input logic              rst,
  input logic              pwm_o,
  input logic              started,
  input logic [SLOT_W-1:0] slot_cnt,
  input logic [SLOT_W-1:0] duty_lat,
  input logic [DIV_W-1:0]  div_cnt,
  input logic [CAL_W-1:0]  cal_cnt
);

  AST_LOW_IN_RESET: assert property (@(posedge clk) rst |=> !pwm_o); // R1

  AST_DUTY_IN_BAND: assert property (@(posedge clk) disable iff (rst)
    started |-> (duty_lat >= SLOT_W'(LO_SLOT) && duty_lat <= SLOT_W'(HI_SLOT))); // R4

  AST_HEAD_HIGH: assert property (@(posedge clk) disable iff (rst)
    (started && slot_cnt < SLOT_W'(LO_SLOT)) |-> pwm_o); // R4

  AST_TAIL_LOW: assert property (@(posedge clk) disable iff (rst)
    (slot_cnt >= SLOT_W'(HI_SLOT)) |-> !pwm_o); // R4

  AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (rst)
    slot_cnt < SLOT_W'(SLOTS)); // R5

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
    (started && (slot_cnt != '0 || div_cnt != '0)) |-> $stable(duty_lat)); // R8

  AST_CAL_MONO: assert property (@(posedge clk) disable iff (rst)
    (cal_cnt >= $past(cal_cnt)) && (cal_cnt <= CAL_W'(CAL_PERIODS))); // R6

endmodule

bind sensor_pwm_gen sensor_pwm_gen_chk #(
  .SLOTS(SLOTS), .SLOT_W(SLOT_W), .DIV_W(DIV_W), .CAL_W(CAL_W),
  .CAL_PERIODS(CAL_PERIODS), .LO_SLOT(LO_SLOT), .HI_SLOT(HI_SLOT)
) u_chk (
  .clk(clk), .rst(rst), .pwm_o(pwm_o), .started(started),
  .slot_cnt(slot_cnt), .duty_lat(duty_lat), .div_cnt(div_cnt), .cal_cnt(cal_cnt)
);

// File: tb/sensor_pwm_gen_tb.sv
module sensor_pwm_gen_tb;
  localparam int FW = 8, SL = 100, DB = 2, DS = 1, CP = 4, SB = 16, SS = 6;
  localparam int LO = 7, HI = 93;

  logic clk = 1'b0, rst = 1'b1;
  logic signed [FW-1:0] field = '0;
  logic [7:0] sens = '0;
  logic [8:0] qdc = '0;
  logic [3:0] freq = '0;
  logic cal_en = 1'b0;
  logic pwm;
  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sensor_pwm_gen #(.FIELD_W(FW), .SLOTS(SL), .DIV_BASE(DB), .DIV_STEP(DS),
    .CAL_PERIODS(CP), .SENS_BASE(SB), .SENS_SHIFT(SS),
    .CLAMP_LO_PCT(7), .CLAMP_HI_PCT(93)) u_dut (
    .clk(clk), .rst(rst), .field_i(field), .sens_trim_i(sens),
    .qdc_trim_i(qdc), .freq_trim_i(freq), .cal_en_i(cal_en), .pwm_o(pwm));

  function automatic int exp_slots(int s, int q, int f, bit cal);
    int qo, r;
    qo = (q >= 256) ? -(q - 255) : q;
    r  = SL / 2 + qo;
    if (!cal) r = r + ((f * (SB + s)) >>> SS);
    if (r < LO) r = LO;
    if (r > HI) r = HI;
    return r;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic sync_rise();
    logic pr;
    pr = pwm;
    @(negedge clk);
    while (!(pwm && !pr)) begin
      pr = pwm;
      @(negedge clk);
    end
  endtask

  task automatic measure(output int h, output int p);
    h = 0; p = 0;
    while (pwm == 1'b1) begin h++; p++; @(negedge clk); end
    while (pwm == 1'b0) begin p++; @(negedge clk); end
  endtask

  task automatic settle_measure(output int h, output int p);
    int h0, p0;
    sync_rise();
    measure(h0, p0);
    measure(h, p);
  endtask

  task automatic do_reset(bit ce);
    @(negedge clk);
    rst = 1'b1;
    cal_en = ce;
    @(negedge clk);
    chk("R1 low in reset", pwm, 0);
    @(negedge clk);
    chk("R1 low in reset", pwm, 0);
    rst = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<190000", cyc);
      report();
    end
  end

  initial begin
    int h, p, d;
    // R1, R6, R9: calibration window right after reset
    field = 8'sd100; sens = 8'd0; qdc = 9'd0; freq = 4'd0;
    do_reset(1'b1);
    sync_rise();
    for (int k = 0; k < CP; k++) begin
      measure(h, p);
      chk("R6 cal window duty", h, exp_slots(0, 0, 100, 1'b1) * DB);
      chk("R5 cal period", p, SL * DB);
    end
    measure(h, p);
    chk("R7 first tracking period", h, exp_slots(0, 0, 100, 1'b0) * DB);

    // R7: no calibration, first period already tracks
    do_reset(1'b0);
    sync_rise();
    measure(h, p);
    chk("R7 no-cal first period", h, exp_slots(0, 0, 100, 1'b0) * DB);

    // R1: reset asserted during run
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    chk("R1 mid-run reset low", pwm, 0);
    @(negedge clk); rst = 1'b0;

    // R2 and R4: quiescent sweep with zero field
    field = '0; sens = 8'd0; freq = 4'd0;
    for (int q = 0; q < 512; q += 11) begin
      qdc = 9'(q);
      settle_measure(h, p);
      chk("R2 quiescent duty", h, exp_slots(0, q, 0, 1'b0) * DB);
    end

    // R3 and R4: field and gain sweep
    qdc = 9'd0;
    for (int si = 0; si < 3; si++) begin
      for (int f = -128; f < 128; f += 17) begin
        int s;
        s = (si == 0) ? 0 : (si == 1) ? 100 : 255;
        sens = 8'(s); field = 8'(f);
        settle_measure(h, p);
        chk("R3 scaled field duty", h, exp_slots(s, 0, f, 1'b0) * DB);
      end
    end

    // R4: explicit clamp corners
    sens = 8'd255; field = 8'sd127; qdc = 9'd0;
    settle_measure(h, p);
    chk("R4 upper clamp", h, HI * DB);
    field = -8'sd128;
    settle_measure(h, p);
    chk("R4 lower clamp", h, LO * DB);

    // R5: every carrier code
    field = '0; sens = '0; qdc = 9'd0;
    for (int c = 0; c < 16; c++) begin
      freq = 4'(c);
      settle_measure(h, p);
      d = DB + c * DS;
      chk("R5 period length", p, SL * d);
      chk("R4 high time scales with slot", h, (SL / 2) * d);
    end

    // R8: change during a period affects only the next period
    freq = 4'd0; field = '0; sens = '0; qdc = 9'd0;
    settle_measure(h, p);
    field = 8'sd127;
    measure(h, p);
    chk("R8 current period unchanged", h, exp_slots(0, 0, 0, 1'b0) * DB);
    measure(h, p);
    chk("R8 next period updated", h, exp_slots(0, 0, 127, 1'b0) * DB);

    done = 1'b1;
    report();
  end
endmodule